// File: doc/BRIEF.md
# Multiprocessor Interrupt Routing Register Block

This block is a memory-mapped register file that steers interrupts to as many as four processors. Each processor owns a 64-bit device mask. A shared 64-bit raw device request vector, sampled from an input pin every cycle, is ANDed with each mask to give that processor's effective request. The OR of an effective request drives the processor's device interrupt line. The block also keeps two small pending vectors, one for inter-processor interrupts (IPI) and one for interval-timer interrupts, and drives each of them straight out as a per-processor interrupt line.

Software reaches the block through a simple request/response slave port. The register index is the byte offset shifted right by six, so every register sits in its own 64-byte slot. Only 64-bit accesses are legal. IPIs can be raised and cleared, and timer interrupts cleared, either through bit fields of a shared miscellaneous register or through dedicated registers that each take a plain per-processor bitmask. Raising an IPI that is already pending, or clearing one that is not, leaves the state alone and pulses a warning output. A timer tick input marks a timer interrupt pending on every processor.

Top module: `intr_route_csr`

## Requirements
- R1: After reset all masks, the sampled raw vector and both pending vectors are zero, every interrupt output is low, and no response is pending.
- R2: Every request gets exactly one response, with rsp_valid high in the cycle after the request. A request with bus_size other than 3 (codes 0, 1 and 2 mean 8, 16 and 32 bits; 3 means 64 bits) returns rsp_err=1 and rsp_rdata=0 and changes no state. A legal access returns rsp_err=0.
- R3: The register index is bus_addr[AW-1:6]. Index 0 (control) and indices 1 to 4 (arbitration) read zero. Writes to them, to index 6 and to any unused index are ignored, and unused indices read zero. Legal writes return rsp_rdata=0.
- R4: Index 8+n holds the mask of processor n (read/write). Index 12+n reads the effective request of processor n, the AND of its mask and the sampled raw vector. Index 6 reads the raw vector as it was sampled at the previous clock edge.
- R5: dev_irq[n] is the OR of processor n's effective request, one cycle after either the mask write or the raw input change.
- R6: A write to the miscellaneous register (index 5) raises IPIs for the processors set in bits 15:12, clears IPIs for those set in bits 11:8 and clears timer interrupts for those set in bits 7:4. When one write both raises and clears the same IPI, the clear wins. Bit 28 (a non-existent-memory acknowledge) and all other bits have no effect.
- R7: Writing index 18 raises IPIs from bitmask bits 3:0. Writing index 16 clears IPIs from bits 3:0. Writing index 17 clears timer interrupts from bits 3:0. Indices 16 and 17 read the IPI and timer pending vectors in bits 3:0, and index 18 reads zero.
- R8: ipi_warn is high for one cycle after a legal write that raises an IPI that is already pending or clears an IPI that is not pending. The pending state of those bits is unchanged.
- R9: A cycle with timer_tick high sets every timer pending bit. A tick wins over a timer clear in the same cycle.
- R10: A read of the miscellaneous register returns bus_cpu in bits 1:0, the timer pending vector in bits 7:4, the IPI pending vector in bits 11:8, and zero elsewhere.
- R11: ipi_irq and tmr_irq equal the IPI and timer pending vectors, and they change at the clock edge that accepts the write or the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset from the block base |
| bus_size | input | 2 | Access size code, 3 = 64-bit |
| bus_wdata | input | DW | Write data |
| bus_cpu | input | 2 | ID of the requesting processor |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Illegal access size |
| rsp_rdata | output | DW | Read data |
| dev_req | input | DW | Raw device request vector |
| timer_tick | input | 1 | Interval-timer tick |
| dev_irq | output | NCPU | Device interrupt per processor |
| tmr_irq | output | NCPU | Timer interrupt per processor |
| ipi_irq | output | NCPU | Inter-processor interrupt per processor |
| ipi_warn | output | 1 | Redundant IPI raise or clear |

## Verification
Every result of this block is due exactly one cycle after its cause. A request accepted at a rising edge has its response, and its effect on the masks and pending vectors, visible after that edge. A raw-vector change or tick sampled at an edge shows on dev_irq or tmr_irq after the same edge. Read data reflects the state before the accepting edge. The bench applies each stimulus just after a falling edge, lets one rising edge pass, and compares every output at the next falling edge against a bench model that is updated at that same edge. Each check therefore lines up with the single register stage between cause and result.

// File: rtl/intr_route_csr.sv
module intr_route_csr #(
  parameter int NCPU = 4,
  parameter int DW   = 64,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [1:0]      bus_size,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [1:0]      bus_cpu,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [DW-1:0]   rsp_rdata,
  input  logic [DW-1:0]   dev_req,
  input  logic            timer_tick,
  output logic [NCPU-1:0] dev_irq,
  output logic [NCPU-1:0] tmr_irq,
  output logic [NCPU-1:0] ipi_irq,
  output logic            ipi_warn
);
  localparam int IW = AW - 6;
  localparam logic [IW-1:0] IX_MISC = IW'(5);
  localparam logic [IW-1:0] IX_RAW  = IW'(6);
  localparam logic [IW-1:0] IX_IPIS = IW'(16);
  localparam logic [IW-1:0] IX_TMRS = IW'(17);
  localparam logic [IW-1:0] IX_IPIQ = IW'(18);
  localparam int MASK_BASE = 8;
  localparam int EFF_BASE  = 12;

  logic [NCPU-1:0][DW-1:0] mask_q;
  logic [NCPU-1:0][DW-1:0] eff;
  logic [DW-1:0]   raw_q;
  logic [NCPU-1:0] ipi_q, tmr_q;
  logic            warn_q;

  wire [IW-1:0] idx  = bus_addr[AW-1:6];
  wire          full = (bus_size == 2'd3);
  wire          wr   = bus_valid & full & bus_write;
  wire          rd   = bus_valid & full & ~bus_write;

  for (genvar n = 0; n < NCPU; n++) begin : g_cpu
    assign eff[n]     = mask_q[n] & raw_q;
    assign dev_irq[n] = |eff[n];
  end

  logic [NCPU-1:0] ipi_set, ipi_clr, tmr_clr;
  always_comb begin
    ipi_set = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    if (wr) begin
      case (idx)
        IX_MISC: begin
          ipi_set = bus_wdata[12 +: NCPU];
          ipi_clr = bus_wdata[8 +: NCPU];
          tmr_clr = bus_wdata[4 +: NCPU];
        end
        IX_IPIQ: ipi_set = bus_wdata[NCPU-1:0];
        IX_IPIS: ipi_clr = bus_wdata[NCPU-1:0];
        IX_TMRS: tmr_clr = bus_wdata[NCPU-1:0];
        default: ;
      endcase
    end
  end

  wire [NCPU-1:0] ipi_next  = (ipi_q | ipi_set) & ~ipi_clr;
  wire [NCPU-1:0] tmr_next  = timer_tick ? {NCPU{1'b1}} : (tmr_q & ~tmr_clr);
  wire            warn_next = (|(ipi_set & ipi_q)) | (|(ipi_clr & ~ipi_q));

  logic [DW-1:0] rd_data;
  always_comb begin
    rd_data = '0;
    case (idx)
      IX_MISC: begin
        rd_data[1:0]       = bus_cpu;
        rd_data[4 +: NCPU] = tmr_q;
        rd_data[8 +: NCPU] = ipi_q;
      end
      IX_RAW:  rd_data = raw_q;
      IX_IPIS: rd_data[NCPU-1:0] = ipi_q;
      IX_TMRS: rd_data[NCPU-1:0] = tmr_q;
      default: ;
    endcase
    for (int n = 0; n < NCPU; n++) begin
      if (idx == IW'(MASK_BASE + n)) rd_data = mask_q[n];
      if (idx == IW'(EFF_BASE + n))  rd_data = eff[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      raw_q     <= '0;
      ipi_q     <= '0;
      tmr_q     <= '0;
      warn_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      raw_q  <= dev_req;
      ipi_q  <= ipi_next;
      tmr_q  <= tmr_next;
      warn_q <= warn_next;
      for (int n = 0; n < NCPU; n++)
        if (wr && idx == IW'(MASK_BASE + n)) mask_q[n] <= bus_wdata;
      rsp_valid <= bus_valid;
      rsp_err   <= bus_valid & ~full;
      rsp_rdata <= rd ? rd_data : '0;
    end
  end

  assign tmr_irq  = tmr_q;
  assign ipi_irq  = ipi_q;
  assign ipi_warn = warn_q;
endmodule

// File: rtl/intr_route_chk.sv
module intr_route_chk #(
  parameter int NCPU = 4,
  parameter int DW   = 64,
  parameter int AW   = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_valid,
  input logic            bus_write,
  input logic [1:0]      bus_size,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic [DW-1:0]   rsp_rdata,
  input logic [DW-1:0]   dev_req,
  input logic            timer_tick,
  input logic [NCPU-1:0] dev_irq,
  input logic [NCPU-1:0] tmr_irq,
  input logic [NCPU-1:0] ipi_irq,
  input logic            ipi_warn
);
  // R2
  size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_size != 2'd3) |=> (rsp_err && rsp_rdata == '0));

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> rsp_valid);

  // R2
  no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !rsp_valid);

  // R2
  err_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_size != 2'd3 && !timer_tick) |=> ($stable(ipi_irq) && $stable(tmr_irq) && !ipi_warn));

  // R5
  dev_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req == '0) |=> (dev_irq == '0));

  // R9
  tick_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_tick |=> (&tmr_irq));

  // R11
  ipi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> $stable(ipi_irq));

  // R8
  warn_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> !ipi_warn);
endmodule

bind intr_route_csr intr_route_chk #(.NCPU(NCPU), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_size(bus_size), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .dev_req(dev_req), .timer_tick(timer_tick),
  .dev_irq(dev_irq), .tmr_irq(tmr_irq), .ipi_irq(ipi_irq), .ipi_warn(ipi_warn)
);

// File: tb/sim_intr_route_csr.sv
`timescale 1ns/1ps
module sim_intr_route_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [1:0]  bus_size = '0, bus_cpu = '0;
  logic [63:0] bus_wdata = '0, dev_req = '0;
  logic        timer_tick = 1'b0;
  logic        rsp_valid, rsp_err, ipi_warn;
  logic [63:0] rsp_rdata;
  logic [3:0]  dev_irq, tmr_irq, ipi_irq;

  intr_route_csr u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dev_req(dev_req), .timer_tick(timer_tick),
    .dev_irq(dev_irq), .tmr_irq(tmr_irq), .ipi_irq(ipi_irq), .ipi_warn(ipi_warn)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [63:0] m_mask [4];
  logic [63:0] m_raw = '0;
  logic [3:0]  m_ipi = '0, m_tmr = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_read(input logic [11:0] a, input logic [1:0] cpu);
    logic [5:0] ix = a[11:6];
    logic [63:0] r = '0;
    if (ix == 6'd5) begin r[1:0] = cpu; r[7:4] = m_tmr; r[11:8] = m_ipi; end
    else if (ix == 6'd6) r = m_raw;
    else if (ix >= 6'd8 && ix <= 6'd11) r = m_mask[ix - 6'd8];
    else if (ix >= 6'd12 && ix <= 6'd15) r = m_mask[ix - 6'd12] & m_raw;
    else if (ix == 6'd16) r[3:0] = m_ipi;
    else if (ix == 6'd17) r[3:0] = m_tmr;
    return r;
  endfunction

  task automatic cyc(input bit v, input bit we, input logic [11:0] a, input logic [1:0] sz,
                     input logic [63:0] wd, input logic [1:0] cpu, input bit tk,
                     input logic [63:0] rawv, input string tag);
    logic [63:0] e_rd;
    logic [3:0] s, c, tc;
    logic [5:0] ix;
    bit e_warn, legal;
    logic [3:0] e_dev;
    bus_valid = v; bus_write = we; bus_addr = a; bus_size = sz;
    bus_wdata = wd; bus_cpu = cpu; timer_tick = tk; dev_req = rawv;
    legal = v && sz == 2'd3;
    ix = a[11:6];
    e_rd = (legal && !we) ? exp_read(a, cpu) : 64'd0;
    s = '0; c = '0; tc = '0;
    if (legal && we) begin
      if (ix == 6'd5) begin s = wd[15:12]; c = wd[11:8]; tc = wd[7:4]; end
      else if (ix == 6'd18) s = wd[3:0];
      else if (ix == 6'd16) c = wd[3:0];
      else if (ix == 6'd17) tc = wd[3:0];
      if (ix >= 6'd8 && ix <= 6'd11) m_mask[ix - 6'd8] = wd;
    end
    e_warn = (|(s & m_ipi)) || (|(c & ~m_ipi));
    @(posedge clk);
    m_raw = rawv;
    m_ipi = (m_ipi | s) & ~c;
    m_tmr = tk ? 4'hF : (m_tmr & ~tc);
    for (int n = 0; n < 4; n++) e_dev[n] = |(m_mask[n] & m_raw);
    @(negedge clk);
    bus_valid = 1'b0; timer_tick = 1'b0;
    chk(rsp_valid == v, "R2", "rsp_valid", 64'(rsp_valid), 64'(v));
    if (v) begin
      chk(rsp_err == !legal, "R2", "rsp_err", 64'(rsp_err), 64'(!legal));
      chk(rsp_rdata == e_rd, tag, "rsp_rdata", rsp_rdata, e_rd);
    end
    chk(dev_irq == e_dev, "R5", "dev_irq", 64'(dev_irq), 64'(e_dev));
    chk(tmr_irq == m_tmr, "R9", "tmr_irq", 64'(tmr_irq), 64'(m_tmr));
    chk(ipi_irq == m_ipi, "R11", "ipi_irq", 64'(ipi_irq), 64'(m_ipi));
    chk(ipi_warn == e_warn, "R8", "ipi_warn", 64'(ipi_warn), 64'(e_warn));
  endtask

  function automatic logic [11:0] ra(input int ix);
    return 12'(ix << 6);
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] r;
    int ix;
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 4; n++) m_mask[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(rsp_valid == 0 && dev_irq == 0 && tmr_irq == 0 && ipi_irq == 0 && ipi_warn == 0,
        "R1", "outputs after reset", {dev_irq, tmr_irq, ipi_irq}, 0);
    cyc(1, 0, ra(10), 3, 0, 0, 0, 0, "R1");
    cyc(1, 0, ra(16), 3, 0, 0, 0, 0, "R1");
    // R3 zero and reserved registers
    cyc(1, 1, ra(0), 3, '1, 0, 0, 0, "R3");
    cyc(1, 0, ra(0), 3, 0, 0, 0, 0, "R3");
    cyc(1, 0, ra(3), 3, 0, 0, 0, 0, "R3");
    cyc(1, 1, ra(30), 3, '1, 0, 0, 0, "R3");
    cyc(1, 0, ra(30), 3, 0, 0, 0, 0, "R3");
    // R4 R5 mask and raw
    cyc(0, 0, 0, 0, 0, 0, 0, 64'h10, "R5");
    cyc(1, 1, ra(9), 3, 64'h30, 0, 0, 64'h10, "R4");
    cyc(1, 0, ra(13), 3, 0, 0, 0, 64'h10, "R4");
    cyc(1, 0, ra(6), 3, 0, 0, 0, 64'h10, "R4");
    cyc(1, 1, ra(6), 3, 64'hFF, 0, 0, 64'h20, "R3");
    cyc(1, 0, ra(6), 3, 0, 0, 0, 64'h0, "R4");
    cyc(1, 0, ra(9), 3, 0, 0, 0, 64'h8000_0000_0000_0000, "R4");
    // R6 R8 miscellaneous register
    cyc(1, 1, ra(5), 3, 64'h5000, 0, 0, 0, "R6");
    cyc(1, 1, ra(5), 3, 64'h1000, 0, 0, 0, "R8");
    cyc(1, 1, ra(5), 3, 64'h0200, 0, 0, 0, "R8");
    cyc(1, 1, ra(5), 3, 64'h8800, 0, 0, 0, "R6");
    cyc(1, 1, ra(5), 3, 64'h1000_0000, 0, 0, 0, "R6");
    // R7 dedicated registers
    cyc(1, 1, ra(18), 3, 64'hA, 0, 0, 0, "R7");
    cyc(1, 0, ra(16), 3, 0, 0, 0, 0, "R7");
    cyc(1, 1, ra(16), 3, 64'h3, 0, 0, 0, "R7");
    cyc(1, 0, ra(18), 3, 0, 0, 0, 0, "R7");
    // R9 R10 timer
    cyc(0, 0, 0, 0, 0, 0, 1, 0, "R9");
    cyc(1, 1, ra(5), 3, 64'h30, 0, 0, 0, "R6");
    cyc(1, 0, ra(5), 3, 0, 2'd2, 0, 0, "R10");
    cyc(1, 0, ra(17), 3, 0, 0, 0, 0, "R7");
    cyc(1, 1, ra(17), 3, 64'hF, 0, 1, 0, "R9");
    cyc(1, 1, ra(17), 3, 64'h5, 0, 0, 0, "R7");
    cyc(1, 0, ra(5), 3, 0, 2'd3, 0, 0, "R10");
    // R2 illegal sizes
    for (int z = 0; z < 3; z++) cyc(1, 1, ra(8), 2'(z), '1, 0, 0, 64'hF, "R2");
    cyc(1, 1, ra(5), 2'd1, 64'hF000, 0, 0, 64'hF, "R2");
    cyc(1, 0, ra(8), 2'd2, 0, 0, 0, 64'hF, "R2");
    cyc(1, 0, ra(8), 3, 0, 0, 0, 64'hF, "R2");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      ix = $urandom_range(0, 19);
      if (ix == 19) ix = 40;
      r = {$urandom, $urandom};
      if (ix == 5) r = r & 64'h1000_FFF0;
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, ra(ix),
          ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 2)) : 2'd3,
          r, 2'($urandom_range(0, 3)), $urandom_range(0, 7) == 0,
          {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}, "R4");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule